// File: doc/BRIEF.md
# Register-Controlled Full-Duplex Serial Port with Nine-Bit Framing

This block is an asynchronous serial transmitter and receiver that a processor drives through two 8-bit locations on a simple register bus. One location is the control and status register. The other is a data location shared by both directions. A write to the data location hands a byte to the transmitter. A read of it returns the last byte the receiver completed. Transmit and receive run at the same time, each with its own shifter and bit timer. Both are paced by one oversampling tick that runs at sixteen times the bit rate and comes from an internal clock divider.

Each frame carries eight data bits, least significant first, between a low start bit and a high stop bit. An optional ninth data bit can sit between the data and the stop bit. On transmit that ninth bit comes from a control field. On receive it is stored in a second control field. A completed receive byte moves into a holding latch, so the receive shifter is free for the next frame at once. Two sticky completion flags record a finished transmission and a finished reception. Only a software write clears them. A single interrupt line reports any flag whose enable is set.

Top module: `uart9_port`

## Requirements
- R1: After reset, both bus locations read 0x00, `txd` is high and `irq` is low.
- R2: Writing the data location (`bus_addr`=1) while the transmitter is idle sends a frame on `txd`: one low start bit, eight data bits LSB first and one high stop bit. Each bit lasts 16 oversampling ticks, and one tick comes every `DIV` clocks.
- R3: When control bit 4 (nine-bit mode) is set, the transmitter inserts control bit 2 as a ninth bit between the data bits and the stop bit.
- R4: Control bit 0 (transmit flag) becomes 1 when a frame has fully left the shifter. A data write made while a frame is still shifting is ignored and does not disturb that frame.
- R5: A read of the data location returns the receive latch and never the byte last written for transmission.
- R6: With control bit 5 (receiver enable) set and nine-bit mode clear, a frame with a high stop bit places its eight data bits in the receive latch, sets control bit 1 (receive flag) and clears control bit 3.
- R7: In nine-bit mode, a received frame stores its ninth bit in control bit 3.
- R8: Both flags are sticky. A control write with 0 in a flag bit clears that flag, a 1 leaves it as it is, and nothing else clears it. Control bits 2, 4, 5, 6 and 7 take the written value.
- R9: `irq` is high exactly when (transmit flag and bit 6) or (receive flag and bit 7).
- R10: A low pulse on `rxd` that is high again at the middle of the start bit is treated as noise. No byte is taken, and the next real frame is received correctly.
- R11: A frame whose stop bit is sampled low is discarded. The latch keeps its old value and the receive flag is not set.
- R12: A frame that completes while the receive flag is still set overwrites the latch, so back-to-back frames are received without software reading in between.
- R13: A transmission and a reception that overlap in time both complete correctly.
- R14: With the receiver enable clear, activity on `rxd` leaves the latch and the receive flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | Register select: 0 control, 1 data |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected location |
| rxd | input | 1 | Serial receive line, asynchronous |
| txd | output | 1 | Serial transmit line, idles high |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the port with `DIV` = 2, so a bit lasts 32 clocks and a nine-bit frame lasts under 400 clocks. That is short enough to cover every framing mode, noise pulses, bad stop bits, back-to-back frames and an overlapped transmit and receive within a short run. The small divider also puts the mid-bit sampling of the receiver and the first-bit phase uncertainty of the transmitter within one or two clocks of the ideal. The mid-bit decoder in the bench therefore checks bit alignment closely rather than loosely.

// File: rtl/uart9_pkg.sv
`timescale 1ns/1ps
package uart9_pkg;

    localparam int OVS       = 16;
    localparam int OVS_W     = $clog2(OVS);
    localparam int HALF_BIT  = OVS / 2 - 1;
    localparam int TXF_W     = 12;
    localparam int RXS_W     = 9;
    localparam int DATA_W    = 8;
    localparam int NB_W      = 4;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_DATA = 1'b1;

    typedef struct packed {
        logic rx_ie;
        logic tx_ie;
        logic rx_en;
        logic nine;
        logic rx_b8;
        logic tx_b8;
        logic rx_flag;
        logic tx_flag;
    } ctrl_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_st_e;

    // Frame image shifted out LSB first; the top 1 is an end marker that
    // lands in bit 0 once the stop bit has been sent (zero detector idea).
    function automatic logic [TXF_W-1:0] tx_frame(input logic nine,
                                                  input logic b8,
                                                  input logic [DATA_W-1:0] d);
        if (nine)
            return {1'b1, 1'b1, b8, d, 1'b0};
        else
            return {1'b0, 1'b1, 1'b1, d, 1'b0};
    endfunction

    function automatic logic [NB_W-1:0] last_bit_idx(input logic nine);
        return nine ? NB_W'(DATA_W) : NB_W'(DATA_W - 1);
    endfunction

endpackage

// File: rtl/uart9_tick.sv
`timescale 1ns/1ps
module uart9_tick #(
    parameter int DIV = 27
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_cnt
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst)
                    cnt <= '0;
                else if (cnt == CW'(DIV - 1))
                    cnt <= '0;
                else
                    cnt <= cnt + 1'b1;
            end
            assign tick = (cnt == CW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/uart9_tx.sv
`timescale 1ns/1ps
module uart9_tx
    import uart9_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load,
    input  logic              nine,
    input  logic              b8,
    input  logic [DATA_W-1:0] data,
    output logic              txd,
    output logic              busy,
    output logic              done
);
    logic [TXF_W-1:0] sh;
    logic [OVS_W-1:0] ph;
    logic [TXF_W-1:0] sh_next;

    assign sh_next = sh >> 1;
    assign busy    = (sh[TXF_W-1:1] != '0);
    assign txd     = sh[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= TXF_W'(1);
            ph   <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load && !busy) begin
                sh <= tx_frame(nine, b8, data);
                ph <= '0;
            end else if (busy && tick) begin
                ph <= ph + 1'b1;
                if (ph == OVS_W'(OVS - 1)) begin
                    sh   <= sh_next;
                    done <= (sh_next == TXF_W'(1));
                end
            end
        end
    end
endmodule

// File: rtl/uart9_rx.sv
`timescale 1ns/1ps
module uart9_rx
    import uart9_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              en,
    input  logic              nine,
    input  logic              rxd,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              b8
);
    logic [1:0]       sync;
    logic             line;
    rx_st_e           st;
    logic [OVS_W-1:0] ph;
    logic [NB_W-1:0]  nb;
    logic [RXS_W-1:0] sh;

    assign line = sync[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync <= 2'b11;
            st   <= RX_IDLE;
            ph   <= '0;
            nb   <= '0;
            sh   <= '0;
            done <= 1'b0;
            data <= '0;
            b8   <= 1'b0;
        end else begin
            sync <= {sync[0], rxd};
            done <= 1'b0;
            case (st)
                RX_IDLE: begin
                    if (en && !line) begin
                        st <= RX_START;
                        ph <= '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        ph <= ph + 1'b1;
                        if (ph == OVS_W'(HALF_BIT)) begin
                            ph <= '0;
                            nb <= '0;
                            st <= line ? RX_IDLE : RX_DATA;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        ph <= ph + 1'b1;
                        if (ph == OVS_W'(OVS - 1)) begin
                            sh <= {line, sh[RXS_W-1:1]};
                            nb <= nb + 1'b1;
                            if (nb == last_bit_idx(nine))
                                st <= RX_STOP;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        ph <= ph + 1'b1;
                        if (ph == OVS_W'(OVS - 1)) begin
                            st <= RX_IDLE;
                            if (line) begin
                                done <= 1'b1;
                                data <= nine ? sh[DATA_W-1:0] : sh[RXS_W-1:1];
                                b8   <= nine & sh[RXS_W-1];
                            end
                        end
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart9_port.sv
`timescale 1ns/1ps
module uart9_port
    import uart9_pkg::*;
#(
    parameter int DIV = 27
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       rxd,
    output logic       txd,
    output logic       irq
);
    ctrl_t             ctrl_q;
    ctrl_t             wr_c;
    logic [DATA_W-1:0] rx_buf;
    logic              tick;
    logic              wr_ctrl;
    logic              wr_data;
    logic              tx_busy;
    logic              tx_done;
    logic              rx_done;
    logic [DATA_W-1:0] rx_data;
    logic              rx_b8;

    assign wr_c    = ctrl_t'(bus_wdata);
    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_data = bus_wr && (bus_addr == ADDR_DATA);

    uart9_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    uart9_tx u_tx (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .load (wr_data),
        .nine (ctrl_q.nine),
        .b8   (ctrl_q.tx_b8),
        .data (bus_wdata),
        .txd  (txd),
        .busy (tx_busy),
        .done (tx_done)
    );

    uart9_rx u_rx (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .en   (ctrl_q.rx_en),
        .nine (ctrl_q.nine),
        .rxd  (rxd),
        .done (rx_done),
        .data (rx_data),
        .b8   (rx_b8)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            rx_buf <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.rx_ie   <= wr_c.rx_ie;
                ctrl_q.tx_ie   <= wr_c.tx_ie;
                ctrl_q.rx_en   <= wr_c.rx_en;
                ctrl_q.nine    <= wr_c.nine;
                ctrl_q.rx_b8   <= wr_c.rx_b8;
                ctrl_q.tx_b8   <= wr_c.tx_b8;
                ctrl_q.rx_flag <= ctrl_q.rx_flag & wr_c.rx_flag;
                ctrl_q.tx_flag <= ctrl_q.tx_flag & wr_c.tx_flag;
            end
            if (tx_done)
                ctrl_q.tx_flag <= 1'b1;
            if (rx_done) begin
                ctrl_q.rx_flag <= 1'b1;
                ctrl_q.rx_b8   <= rx_b8;
                rx_buf         <= rx_data;
            end
        end
    end

    assign bus_rdata = (bus_addr == ADDR_DATA) ? rx_buf : ctrl_q;
    assign irq = (ctrl_q.tx_flag & ctrl_q.tx_ie) | (ctrl_q.rx_flag & ctrl_q.rx_ie);

endmodule

// File: rtl/uart9_port_chk.sv
`timescale 1ns/1ps
module uart9_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       txd,
    input logic       irq,
    input logic       bus_wr,
    input logic       bus_addr,
    input logic [7:0] ctrl,
    input logic       tx_busy,
    input logic       rx_done,
    input logic [7:0] rx_buf
);
    // R2: line rests high whenever no frame is in the shifter
    a_r2_idle_line_high: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> txd);

    // R4: transmit flag only appears once the shifter has emptied
    a_r4_flag_after_frame: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl[0]) |-> $past(!tx_busy));

    // R8: no clearing of the transmit flag without a control write
    a_r8_tx_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (ctrl[0] && !(bus_wr && bus_addr == 1'b0)) |=> ctrl[0]);

    // R8: same for the receive flag
    a_r8_rx_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (ctrl[1] && !(bus_wr && bus_addr == 1'b0)) |=> ctrl[1]);

    // R9: interrupt always has a flag behind it
    a_r9_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ctrl[0] || ctrl[1]));

    // R11: receive flag rises only on a completed good frame
    a_r11_flag_needs_frame: assert property (@(posedge clk) disable iff (rst)
        (!ctrl[1] && !rx_done) |=> !ctrl[1]);

    // R12: latch only changes on a completed frame
    a_r12_latch_holds: assert property (@(posedge clk) disable iff (rst)
        !rx_done |=> $stable(rx_buf));
endmodule

bind uart9_port uart9_port_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .txd      (txd),
    .irq      (irq),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .ctrl     (ctrl_q),
    .tx_busy  (tx_busy),
    .rx_done  (rx_done),
    .rx_buf   (rx_buf)
);

// File: tb/uart9_port_bench.sv
`timescale 1ns/1ps
module uart9_port_bench;
    localparam int DIV = 2;
    localparam int BIT = 16 * DIV;
    localparam logic [7:0] C_TXB8 = 8'h04;
    localparam logic [7:0] C_NINE = 8'h10;
    localparam logic [7:0] C_RXEN = 8'h20;
    localparam logic [7:0] C_TXIE = 8'h40;
    localparam logic [7:0] C_RXIE = 8'h80;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_addr = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       rx_line = 1'b1;
    logic       txd;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    logic [9:0] tx_q[$];

    always #2 clk = ~clk;

    uart9_port #(.DIV(DIV)) u_uart9_port (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rxd       (rx_line),
        .txd       (txd),
        .irq       (irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic send_tx(input logic [7:0] d, input logic nine, input logic b8);
        tx_q.push_back({nine, b8, d});
        wr(1'b1, d);
    endtask

    task automatic send_rx(input logic [7:0] d, input logic nine,
                           input logic b8, input logic stopb);
        rx_line = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_line = d[i];
            repeat (BIT) @(negedge clk);
        end
        if (nine) begin
            rx_line = b8;
            repeat (BIT) @(negedge clk);
        end
        rx_line = stopb;
        repeat (BIT) @(negedge clk);
        rx_line = 1'b1;
    endtask

    task automatic gap(input int bits);
        repeat (bits * BIT) @(negedge clk);
    endtask

    // Monitor: decode each frame on txd at mid-bit and compare with the queue
    always begin : tx_mon
        logic [9:0] e;
        logic [7:0] got_d;
        logic       got_b8;
        logic       s0;
        logic       sp;
        logic       have;
        @(negedge txd);
        have = (tx_q.size() != 0);
        e = have ? tx_q.pop_front() : 10'h0;
        if (!have) check("R4", "unexpected frame on txd", 32'd1, 32'd0);
        repeat (BIT / 2) @(posedge clk);
        #1 s0 = txd;
        for (int i = 0; i < 8; i++) begin
            repeat (BIT) @(posedge clk);
            #1 got_d[i] = txd;
        end
        got_b8 = 1'b0;
        if (e[9]) begin
            repeat (BIT) @(posedge clk);
            #1 got_b8 = txd;
        end
        repeat (BIT) @(posedge clk);
        #1 sp = txd;
        if (have) begin
            check(e[9] ? "R3" : "R2", "tx start bit", {31'd0, s0}, 32'd0);
            check(e[9] ? "R3" : "R2", "tx data", {24'd0, got_d}, {24'd0, e[7:0]});
            if (e[9]) check("R3", "tx ninth bit", {31'd0, got_b8}, {31'd0, e[8]});
            check(e[9] ? "R3" : "R2", "tx stop bit", {31'd0, sp}, 32'd1);
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : seq
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, v); check("R1", "ctrl after reset", {24'd0, v}, 32'h00);
        rd(1'b1, v); check("R1", "data after reset", {24'd0, v}, 32'h00);
        check("R1", "txd after reset", {31'd0, txd}, 32'd1);
        check("R1", "irq after reset", {31'd0, irq}, 32'd0);

        // R2, R4, R9: eight-bit transmit with interrupt enabled
        wr(1'b0, C_RXEN | C_TXIE);
        send_tx(8'hA5, 1'b0, 1'b0);
        gap(12);
        rd(1'b0, v); check("R4", "tx flag after frame", {31'd0, v[0]}, 32'd1);
        check("R9", "irq from tx flag", {31'd0, irq}, 32'd1);
        // R5: data read returns receive latch, not the sent byte
        rd(1'b1, v); check("R5", "data read shows rx latch", {24'd0, v}, 32'h00);

        // R8: writing 1 keeps the flag, writing 0 clears it
        wr(1'b0, C_RXEN | C_TXIE | 8'h01);
        gap(1);
        rd(1'b0, v); check("R8", "tx flag kept by write of 1", {31'd0, v[0]}, 32'd1);
        wr(1'b0, C_RXEN | C_TXIE);
        rd(1'b0, v); check("R8", "tx flag cleared by write of 0", {31'd0, v[0]}, 32'd0);
        check("R9", "irq drops with flag", {31'd0, irq}, 32'd0);

        // R4: write while busy is ignored
        send_tx(8'h3C, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        wr(1'b1, 8'hFF);
        gap(12);
        check("R4", "no extra frame queued", tx_q.size(), 32'd0);

        // R3: nine-bit transmit, ninth bit 1 then 0
        wr(1'b0, C_NINE | C_TXB8);
        send_tx(8'h5A, 1'b1, 1'b1);
        gap(13);
        wr(1'b0, C_NINE);
        send_tx(8'h81, 1'b1, 1'b0);
        gap(13);
        rd(1'b0, v); check("R9", "irq off with tx enable clear", {31'd0, irq}, 32'd0);

        // R6: eight-bit receive
        wr(1'b0, C_RXEN | C_RXIE);
        send_rx(8'h96, 1'b0, 1'b0, 1'b1);
        gap(1);
        rd(1'b0, v); check("R6", "rx flag", {31'd0, v[1]}, 32'd1);
        check("R6", "rx ninth cleared in 8-bit mode", {31'd0, v[3]}, 32'd0);
        check("R9", "irq from rx flag", {31'd0, irq}, 32'd1);
        rd(1'b1, v); check("R6", "rx byte", {24'd0, v}, 32'h96);

        // R7: nine-bit receive
        wr(1'b0, C_RXEN | C_NINE);
        send_rx(8'h3C, 1'b1, 1'b1, 1'b1);
        gap(1);
        rd(1'b0, v); check("R7", "rx ninth bit stored", {31'd0, v[3]}, 32'd1);
        check("R7", "rx flag nine-bit", {31'd0, v[1]}, 32'd1);
        rd(1'b1, v); check("R7", "rx byte nine-bit", {24'd0, v}, 32'h3C);

        // R11: bad stop bit discards the frame
        wr(1'b0, C_RXEN | C_NINE);
        send_rx(8'h11, 1'b1, 1'b0, 1'b0);
        gap(3);
        rd(1'b0, v); check("R11", "no flag on bad stop", {31'd0, v[1]}, 32'd0);
        rd(1'b1, v); check("R11", "latch kept on bad stop", {24'd0, v}, 32'h3C);

        // R10: short low glitch rejected, next frame fine
        wr(1'b0, C_RXEN);
        rx_line = 1'b0;
        repeat (3 * DIV) @(negedge clk);
        rx_line = 1'b1;
        gap(2);
        rd(1'b0, v); check("R10", "no flag after glitch", {31'd0, v[1]}, 32'd0);
        send_rx(8'h42, 1'b0, 1'b0, 1'b1);
        gap(1);
        rd(1'b1, v); check("R10", "frame after glitch", {24'd0, v}, 32'h42);

        // R12: back-to-back frames, no read or clear in between
        wr(1'b0, C_RXEN);
        send_rx(8'h11, 1'b0, 1'b0, 1'b1);
        rd(1'b1, v); check("R12", "first of pair latched", {24'd0, v}, 32'h11);
        send_rx(8'h22, 1'b0, 1'b0, 1'b1);
        gap(1);
        rd(1'b1, v); check("R12", "second of pair overwrites", {24'd0, v}, 32'h22);
        rd(1'b0, v); check("R12", "flag still set", {31'd0, v[1]}, 32'd1);

        // R14: receiver disabled ignores the line
        wr(1'b0, 8'h00);
        send_rx(8'h77, 1'b0, 1'b0, 1'b1);
        gap(1);
        rd(1'b0, v); check("R14", "no flag when disabled", {31'd0, v[1]}, 32'd0);
        rd(1'b1, v); check("R14", "latch unchanged when disabled", {24'd0, v}, 32'h22);

        // R13: overlapped transmit and receive
        wr(1'b0, C_RXEN);
        fork
            send_tx(8'hC3, 1'b0, 1'b0);
            send_rx(8'h5E, 1'b0, 1'b0, 1'b1);
        join
        gap(2);
        rd(1'b0, v); check("R13", "both flags set", {30'd0, v[1:0]}, 32'd3);
        rd(1'b1, v); check("R13", "rx byte during tx", {24'd0, v}, 32'h5E);
        check("R13", "all tx frames seen", tx_q.size(), 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule